// File: doc/BRIEF.md
# Sigma-Delta Channel Interrupt Flag Controller

This block gathers the event strobes of a bank of sigma-delta filter channels and keeps them as sticky flags in one status word. Each channel reports four kinds of event: a threshold crossing at the high limit, a threshold crossing at the low limit, a modulator failure, and fresh filter data. Every event kind has its own per-channel enable. A global interrupt enable gates all flag setting and the interrupt line.

Software reads the status word through a registered read port. It clears flags by writing ones to a write-one-to-clear register. A sticky summary flag in the top bit reports that at least one flag has been raised. Each rising edge of the summary flag produces a one-cycle low pulse on the active-low interrupt output. If software clears the summary flag while channel flags are still pending, the summary flag sets again on the next cycle and the interrupt is pulsed again. A hardware set of a channel flag always beats a software clear of the same bit in the same cycle.

Top module: `sdirq_ctrl`

## Requirements
- R1: Status word layout for channel c (0..3): high-threshold flag at bit 2c, low-threshold flag at bit 2c+1, modulator-failure flag at bit 8+c, new-data flag at bit 12+c, summary flag at bit 31. Bits 16..30 always read 0.
- R2: An event strobe sets its flag on the clock edge where it is high, provided its per-channel enable and the global enable are both 1. The flag stays at 1 until software clears it.
- R3: An event whose per-channel enable is 0 leaves its flag at 0.
- R4: While the global enable is 0, no channel flag can be set and `irq_n` stays at 1, even if the summary flag rises.
- R5: When `wr_en` is high, each 1 in `wr_data` clears the matching flag. Bits written as 0 and the bits in 16..30 have no effect.
- R6: If a flag's event and its clear fall in the same cycle, the flag ends at 1.
- R7: The summary flag becomes 1 one cycle after any channel flag is 1, and stays set until cleared through bit 31. If it is cleared while channel flags are still pending, it is 1 again one cycle after the clearing edge.
- R8: `irq_n` is driven low for exactly one cycle, in the cycle after each rising edge of the summary flag, provided the global enable is 1.
- R9: After synchronous reset, all flags and `rd_data` are 0 and `irq_n` is 1.
- R10: `rd_data` is updated one cycle after each edge. It returns the status word when `rd_sel` is 0, and all zeros (the clear register) when `rd_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global interrupt enable |
| en_hi | input | NCH | Per-channel enables for high-threshold flags |
| en_lo | input | NCH | Per-channel enables for low-threshold flags |
| en_fail | input | NCH | Per-channel enables for modulator-failure flags |
| en_ack | input | NCH | Per-channel enables for new-data flags |
| evt_hi | input | NCH | High-threshold event strobes |
| evt_lo | input | NCH | Low-threshold event strobes |
| evt_fail | input | NCH | Modulator-failure event strobes |
| evt_ack | input | NCH | New-data event strobes |
| wr_en | input | 1 | Write strobe for the clear register |
| wr_data | input | STAT_W | Clear mask; a 1 clears the matching flag |
| rd_sel | input | 1 | Read select: 0 status word, 1 clear register |
| rd_data | output | STAT_W | Registered read data |
| irq_n | output | 1 | Active-low interrupt pulse |

## Verification
The bench sweeps every event kind on every channel under all four combinations of per-channel and global enable. For each case it checks the exact status word and the cycle-exact shape of the interrupt pulse. A bit-position error would show up as a wrong status word, and a missing gate would raise flags or pulse the line when it must stay quiet. The bench also goes after three races and read-port cases. First, a set coincident with a clear, where a design that let the clear win would drop the flag. Second, clearing the summary flag while flags are pending, where a design that lost the re-set would leave an event unreported, and a design that failed to re-pulse would miss the interrupt. Third, writing zeros and reading with the clear-register select, which must change nothing and must return zeros.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;
  // event kinds; the enum value is the index inside a channel slice
  typedef enum logic [1:0] {
    SRC_HI   = 2'd0,
    SRC_LO   = 2'd1,
    SRC_FAIL = 2'd2,
    SRC_ACK  = 2'd3
  } src_e;

  localparam int NSRC = 4;

  // status-word bit for a given channel and event kind
  function automatic int bitpos(input int nch, input int ch, input int src);
    case (src)
      0:       bitpos = 2 * ch;
      1:       bitpos = 2 * ch + 1;
      2:       bitpos = 2 * nch + ch;
      default: bitpos = 3 * nch + ch;
    endcase
  endfunction
endpackage

// File: rtl/sdirq_chan.sv
module sdirq_chan #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            glb_en_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flag_o
);
  logic [NSRC-1:0] set_w;
  logic [NSRC-1:0] flag_q;

  assign set_w = evt_i & en_i & {NSRC{glb_en_i}};

  // hardware set has priority over a coincident clear
  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~clr_i) | set_w;
  end

  assign flag_o = flag_q;

  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (evt_i[k] && en_i[k] && glb_en_i) |=> flag_o[k]);
    // R5
    clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_i[k] && !evt_i[k]) |=> !flag_o[k]);
    // R3
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (!en_i[k] && !flag_o[k]) |=> !flag_o[k]);
    // R4
    glb_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (!glb_en_i && !flag_o[k]) |=> !flag_o[k]);
  end
endmodule

// File: rtl/sdirq_master.sv
module sdirq_master (
  input  logic clk,
  input  logic rst,
  input  logic glb_en_i,
  input  logic any_i,
  input  logic clr_i,
  output logic mflag_o,
  output logic irq_n_o
);
  logic mflag_q;
  logic mflag_nxt;
  logic irq_q;

  // sticky summary; a clear wins for one cycle, then pending flags re-set it
  assign mflag_nxt = clr_i ? 1'b0 : (mflag_q | any_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      mflag_q <= 1'b0;
      irq_q   <= 1'b1;
    end else begin
      mflag_q <= mflag_nxt;
      irq_q   <= ~(glb_en_i & mflag_nxt & ~mflag_q);
    end
  end

  assign mflag_o = mflag_q;
  assign irq_n_o = irq_q;

  // R7
  mflag_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (any_i && !clr_i) |=> mflag_o);
  // R7
  mflag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !mflag_o);
  // R8
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n_o |=> irq_n_o);
  // R8
  irq_with_mflag_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n_o |-> mflag_o);
  // R4
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !glb_en_i |=> irq_n_o);
endmodule

// File: rtl/sdirq_port.sv
module sdirq_port #(
  parameter int STAT_W = 32,
  parameter int NFLAG  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [NFLAG-1:0]  clr_flags_o,
  output logic              clr_m_o,
  output logic [STAT_W-1:0] rd_data_o
);
  localparam int MBIT = STAT_W - 1;

  logic [STAT_W-1:0] rd_q;
  logic              unused_resv;

  assign clr_flags_o = wr_en_i ? wr_data_i[NFLAG-1:0] : '0;
  assign clr_m_o     = wr_en_i & wr_data_i[MBIT];
  assign unused_resv = ^wr_data_i[MBIT-1:NFLAG];

  // the clear register reads back as zero
  always_ff @(posedge clk) begin
    if (rst)           rd_q <= '0;
    else if (rd_sel_i) rd_q <= '0;
    else               rd_q <= status_i;
  end

  assign rd_data_o = rd_q;

  // R10
  clr_reg_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_sel_i |=> (rd_data_o == '0));
  // R1
  resv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data_o[MBIT-1:NFLAG] == '0));
endmodule

// File: rtl/sdirq_ctrl.sv
module sdirq_ctrl #(
  parameter int NCH    = 4,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glb_en,
  input  logic [NCH-1:0]    en_hi,
  input  logic [NCH-1:0]    en_lo,
  input  logic [NCH-1:0]    en_fail,
  input  logic [NCH-1:0]    en_ack,
  input  logic [NCH-1:0]    evt_hi,
  input  logic [NCH-1:0]    evt_lo,
  input  logic [NCH-1:0]    evt_fail,
  input  logic [NCH-1:0]    evt_ack,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq_n
);
  import sdirq_pkg::*;

  localparam int NFLAG = NSRC * NCH;
  localparam int NPAD  = STAT_W - 1 - NFLAG;

  logic [NFLAG-1:0]  flags;
  logic [NFLAG-1:0]  clr_flags;
  logic              clr_m;
  logic              mflag;
  logic [STAT_W-1:0] status_w;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [NSRC-1:0] ev;
    logic [NSRC-1:0] en;
    logic [NSRC-1:0] cl;
    logic [NSRC-1:0] fl;

    assign ev = {evt_ack[ch], evt_fail[ch], evt_lo[ch], evt_hi[ch]};
    assign en = {en_ack[ch],  en_fail[ch],  en_lo[ch],  en_hi[ch]};

    for (genvar s = 0; s < NSRC; s++) begin : g_src
      localparam int P = bitpos(NCH, ch, s);
      assign cl[s]    = clr_flags[P];
      assign flags[P] = fl[s];
    end

    sdirq_chan #(.NSRC(NSRC)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .glb_en_i (glb_en),
      .en_i     (en),
      .evt_i    (ev),
      .clr_i    (cl),
      .flag_o   (fl)
    );
  end

  sdirq_master u_master (
    .clk      (clk),
    .rst      (rst),
    .glb_en_i (glb_en),
    .any_i    (|flags),
    .clr_i    (clr_m),
    .mflag_o  (mflag),
    .irq_n_o  (irq_n)
  );

  assign status_w = {mflag, {NPAD{1'b0}}, flags};

  sdirq_port #(.STAT_W(STAT_W), .NFLAG(NFLAG)) u_port (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .rd_sel_i    (rd_sel),
    .status_i    (status_w),
    .clr_flags_o (clr_flags),
    .clr_m_o     (clr_m),
    .rd_data_o   (rd_data)
  );
endmodule

// File: tb/tb_sdirq_ctrl.sv
module tb_sdirq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        glb_en = 1'b0;
  logic [3:0]  en_hi = '0, en_lo = '0, en_fail = '0, en_ack = '0;
  logic [3:0]  evt_hi = '0, evt_lo = '0, evt_fail = '0, evt_ack = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        irq_n;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdirq_ctrl #(.NCH(NCH), .STAT_W(32)) dut (
    .clk(clk), .rst(rst), .glb_en(glb_en),
    .en_hi(en_hi), .en_lo(en_lo), .en_fail(en_fail), .en_ack(en_ack),
    .evt_hi(evt_hi), .evt_lo(evt_lo), .evt_fail(evt_fail), .evt_ack(evt_ack),
    .wr_en(wr_en), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  function automatic int pos_of(int s, int c);
    case (s)
      0:       return 2 * c;
      1:       return 2 * c + 1;
      2:       return 8 + c;
      default: return 12 + c;
    endcase
  endfunction

  task automatic put_en(int s, int c, logic v);
    case (s)
      0: en_hi[c] = v;
      1: en_lo[c] = v;
      2: en_fail[c] = v;
      default: en_ack[c] = v;
    endcase
  endtask

  task automatic put_evt(int s, int c, logic v);
    case (s)
      0: evt_hi[c] = v;
      1: evt_lo[c] = v;
      2: evt_fail[c] = v;
      default: evt_ack[c] = v;
    endcase
  endtask

  task automatic write_clr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    nxt();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic clear_all();
    write_clr(32'hFFFF_FFFF);
    nxt(); nxt();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) nxt();
    rst = 1'b0;
    nxt();
    // R9 reset state
    chk("R9 rd_data", rd_data, 32'h0);
    chk("R9 irq_n", {31'b0, irq_n}, 32'h1);

    // R1 R2 R3 R4 R8: every kind, channel and enable combination
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < NCH; c++) begin
        for (int e = 0; e < 2; e++) begin
          for (int g = 0; g < 2; g++) begin
            logic        hit;
            logic [31:0] bitv;
            glb_en = 1'b1;
            clear_all();
            en_hi = '0; en_lo = '0; en_fail = '0; en_ack = '0;
            put_en(s, c, logic'(e));
            glb_en = logic'(g);
            hit  = (e == 1) && (g == 1);
            bitv = 32'h1 << pos_of(s, c);
            put_evt(s, c, 1'b1);
            nxt();
            put_evt(s, c, 1'b0);
            chk("R8 idle before pulse", {31'b0, irq_n}, 32'h1);
            nxt();
            chk(hit ? "R8 pulse low" : "R4 R3 no pulse", {31'b0, irq_n}, {31'b0, ~hit});
            nxt();
            chk("R8 pulse one cycle", {31'b0, irq_n}, 32'h1);
            nxt();
            chk(hit ? "R1 R2 status word" : "R3 R4 flag stays clear",
                rd_data, hit ? (bitv | 32'h8000_0000) : 32'h0);
            if (hit) begin
              // R5: zeros in the mask clear nothing
              write_clr(~bitv & 32'h7FFF_FFFF & 32'h0000_FFFF & 32'h0);
              nxt();
              chk("R5 zero write no effect", rd_data, bitv | 32'h8000_0000);
              // R5: reserved bits clear nothing
              write_clr(32'h7FFF_0000);
              nxt();
              chk("R5 reserved write no effect", rd_data, bitv | 32'h8000_0000);
              // R5 and R7: clear the one flag, summary stays sticky
              write_clr(bitv);
              nxt();
              chk("R5 R7 one flag cleared", rd_data, 32'h8000_0000);
            end
          end
        end
      end
    end

    // R6: set and clear of the same flag in one cycle
    glb_en = 1'b1;
    clear_all();
    en_hi = '1; en_lo = '1; en_fail = '1; en_ack = '1;
    evt_hi[1] = 1'b1;
    wr_en = 1'b1; wr_data = 32'h1 << 2;
    nxt();
    evt_hi[1] = 1'b0; wr_en = 1'b0; wr_data = '0;
    nxt();
    chk("R6 set beats clear", rd_data, 32'h0000_0004);

    // second pending flag
    evt_fail[3] = 1'b1;
    nxt();
    evt_fail[3] = 1'b0;
    repeat (4) nxt();
    chk("R7 summary set", rd_data, 32'h8000_0804);

    // R7 R8: clear only the summary while flags pend
    write_clr(32'h8000_0000);
    chk("R8 idle after clear edge", {31'b0, irq_n}, 32'h1);
    nxt();
    chk("R8 re-pulse", {31'b0, irq_n}, 32'h0);
    chk("R7 summary cleared one cycle", rd_data, 32'h0000_0804);
    nxt();
    chk("R8 re-pulse one cycle", {31'b0, irq_n}, 32'h1);
    chk("R7 summary re-set", rd_data, 32'h8000_0804);

    // R4: with global enable off the summary re-sets but no pulse
    glb_en = 1'b0;
    write_clr(32'h8000_0000);
    nxt();
    chk("R4 no pulse while disabled", {31'b0, irq_n}, 32'h1);
    nxt();
    chk("R4 no pulse while disabled late", {31'b0, irq_n}, 32'h1);
    chk("R4 R7 summary re-set while disabled", rd_data, 32'h8000_0804);

    // R10: clear register reads back as zero
    rd_sel = 1'b1;
    nxt();
    chk("R10 clear register reads zero", rd_data, 32'h0);
    rd_sel = 1'b0;
    nxt();
    chk("R10 status read again", rd_data, 32'h8000_0804);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule